// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a down-counter whose behaviour on reaching zero is set by a 32-bit control entry. Software programs the entry and then writes a start value. The counter then moves down by one on every cycle in which the tick enable is high. On the tick that takes it from one to zero, the counter has expired. Unless the entry is masked, the block then sends out a one-cycle interrupt request. The request carries the entry's vector, delivery mode and trigger type.

The entry also chooses what happens after expiry. In periodic mode the counter reloads itself from the stored start value and keeps running. In one-shot mode it parks at zero until software writes a new start value. The live count can be read back at any time. A simple write port and a combinational read port give access to three word locations:

| Address | Location | Access |
|---|---|---|
| 0 | control entry | read/write |
| 1 | start value | read/write |
| 2 | live count | read-only |

Any other address reads as zero.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset, address 0 reads 0x0001_0000, which means the mask bit is set. Addresses 1 and 2 read 0, and `irq_valid` is low.
- R2: A write to address 1 with value N makes address 2 read N on the next cycle. After that the count falls by exactly one on each cycle with `tick` high, and holds on cycles with `tick` low.
- R3: Expiry is the tick that is accepted while the count is 1. If entry bit 16 is 0 at expiry, `irq_valid` is high in the following cycle. In that same cycle `irq_vector` equals entry bits 7:0, `irq_mode` equals bits 10:8 and `irq_level` equals bit 15.
- R4: If entry bit 16 is 1 at expiry, no request is issued. The counter still follows the periodic or one-shot rule.
- R5: If entry bit 17 is 1 at expiry, the count reloads to the stored start value. The next expiry then follows after another N ticks.
- R6: If entry bit 17 is 0 at expiry, the count stays at 0 and further ticks produce no request until address 1 is written again.
- R7: Writing 0 to address 1 stops the timer. The count reads 0 and no request follows, whatever ticks arrive.
- R8: Writing address 1 while a countdown is running restarts it from the new value. The write takes priority over a tick in the same cycle.
- R9: Writes to address 2 have no effect. Entry bits 12, 14 and 31:18 always read 0. Bits 7:0, 10:8, 13, 15, 16 and 17 read back as written.
- R10: Each expiry gives `irq_valid` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| tick | input | 1 | Count enable, one decrement per high cycle |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |
| irq_mode | output | 3 | Delivery mode of the request |
| irq_level | output | 1 | Trigger type of the request (1 = level) |

## Verification
The hardest case to reach from the ports is an expiry that lands in the same cycle as another event. One such event is a restart write, which must win over the expiry. Another is a periodic reload with a start value of one or two, where requests come as close together as the pulse rule allows.

The bench sweeps start values 1 to 6 against every combination of the mask and periodic bits. It uses both back-to-back ticks and gapped ticks, so the number of requests and the final count can be worked out arithmetically for each case. A separate sequence writes a new start value together with a tick just before expiry. It then checks that the restart wins and that the request is delayed by the full new count.

// File: rtl/irq_tmr_pkg.sv
package irq_tmr_pkg;
   localparam int BUS_W  = 32;
   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_ENTRY = 2'd0;
   localparam logic [ADDR_W-1:0] A_START = 2'd1;
   localparam logic [ADDR_W-1:0] A_LIVE  = 2'd2;

   typedef struct packed {
      logic       periodic;
      logic       mask;
      logic       trigger;
      logic       polarity;
      logic [2:0] mode;
      logic [7:0] vector;
   } lvt_t;

   localparam lvt_t LVT_RESET = '{periodic: 1'b0, mask: 1'b1, trigger: 1'b0,
                                  polarity: 1'b0, mode: 3'd0, vector: 8'd0};

   function automatic lvt_t lvt_unpack(input logic [BUS_W-1:0] w);
      lvt_t e;
      e.vector   = w[7:0];
      e.mode     = w[10:8];
      e.polarity = w[13];
      e.trigger  = w[15];
      e.mask     = w[16];
      e.periodic = w[17];
      return e;
   endfunction

   function automatic logic [BUS_W-1:0] lvt_pack(input lvt_t e);
      return {14'd0, e.periodic, e.mask, e.trigger, 1'b0, e.polarity,
              2'b00, e.mode, e.vector};
   endfunction
endpackage

// File: rtl/irq_tmr_regs.sv
module irq_tmr_regs
   import irq_tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   output lvt_t              entry_q,
   output logic [CNT_W-1:0]  start_q,
   output logic              start_wr,
   output logic [CNT_W-1:0]  start_val
);
   logic entry_wr;

   assign entry_wr  = wr_en && (wr_addr == A_ENTRY);
   assign start_wr  = wr_en && (wr_addr == A_START);
   assign start_val = wr_data[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         entry_q <= LVT_RESET;
         start_q <= '0;
      end else begin
         if (entry_wr) entry_q <= lvt_unpack(wr_data);
         if (start_wr) start_q <= start_val;
      end
   end
endmodule

// File: rtl/irq_tmr_counter.sv
module irq_tmr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             periodic,
   output logic [CNT_W-1:0] cnt_q,
   output logic             run_q,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign expire = run_q && tick && (cnt_q == ONE) && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         run_q <= (load_val != '0);
      end else if (expire) begin
         if (periodic) begin
            cnt_q <= reload_val;
         end else begin
            cnt_q <= '0;
            run_q <= 1'b0;
         end
      end else if (run_q && tick) begin
         cnt_q <= cnt_q - ONE;
      end
   end
endmodule

// File: rtl/irq_tmr_req.sv
module irq_tmr_req
   import irq_tmr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  lvt_t       entry,
   output logic       irq_valid,
   output logic [7:0] irq_vector,
   output logic [2:0] irq_mode,
   output logic       irq_level
);
   logic fire;

   assign fire = expire && !entry.mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_vector <= '0;
         irq_mode   <= '0;
         irq_level  <= 1'b0;
      end else begin
         irq_valid <= fire;
         if (fire) begin
            irq_vector <= entry.vector;
            irq_mode   <= entry.mode;
            irq_level  <= entry.trigger;
         end
      end
   end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
   import irq_tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BUS_W-1:0]  rd_data,
   input  logic              tick,
   output logic              irq_valid,
   output logic [7:0]        irq_vector,
   output logic [2:0]        irq_mode,
   output logic              irq_level
);
   generate
      if (CNT_W < 1 || CNT_W > BUS_W) begin : g_bad_width
         $error("CNT_W must lie between 1 and the bus width");
      end
   endgenerate

   lvt_t             entry_q;
   logic [CNT_W-1:0] start_q;
   logic             start_wr;
   logic [CNT_W-1:0] start_val;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             expire;
   logic             ent_mask;
   logic             ent_periodic;
   logic [BUS_W-1:0] cnt_ext;
   logic [BUS_W-1:0] start_ext;

   assign ent_mask     = entry_q.mask;
   assign ent_periodic = entry_q.periodic;

   irq_tmr_regs #(.CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .entry_q   (entry_q),
      .start_q   (start_q),
      .start_wr  (start_wr),
      .start_val (start_val)
   );

   irq_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .load       (start_wr),
      .load_val   (start_val),
      .reload_val (start_q),
      .periodic   (ent_periodic),
      .cnt_q      (cnt_q),
      .run_q      (run_q),
      .expire     (expire)
   );

   irq_tmr_req u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire     (expire),
      .entry      (entry_q),
      .irq_valid  (irq_valid),
      .irq_vector (irq_vector),
      .irq_mode   (irq_mode),
      .irq_level  (irq_level)
   );

   generate
      if (CNT_W == BUS_W) begin : g_full
         assign cnt_ext   = cnt_q;
         assign start_ext = start_q;
      end else begin : g_narrow
         assign cnt_ext   = {{(BUS_W-CNT_W){1'b0}}, cnt_q};
         assign start_ext = {{(BUS_W-CNT_W){1'b0}}, start_q};
      end
   endgenerate

   always_comb begin
      case (rd_addr)
         A_ENTRY: rd_data = lvt_pack(entry_q);
         A_START: rd_data = start_ext;
         A_LIVE:  rd_data = cnt_ext;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/irq_tmr_chk.sv
module irq_tmr_chk
   import irq_tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [BUS_W-1:0] wr_data,
   input logic             start_wr,
   input logic             irq_valid,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] start_q,
   input logic             run_q,
   input logic             ent_mask,
   input logic             ent_periodic
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic at_end;
   assign at_end = run_q && tick && (cnt_q == ONE) && !start_wr;

   p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick && cnt_q != ONE && !start_wr) |=> cnt_q == $past(cnt_q) - ONE);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !start_wr) |=> $stable(cnt_q));

   p_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> $past(at_end && !ent_mask));

   p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && ent_mask) |=> !irq_valid);

   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && ent_periodic) |=> (cnt_q == $past(start_q)) && run_q);

   p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && !ent_periodic) |=> (cnt_q == '0) && !run_q);

   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !start_wr) |=> $stable(cnt_q) && !run_q);

   p_zero_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && wr_data[CNT_W-1:0] == '0) |=> !run_q);

   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> cnt_q == $past(wr_data[CNT_W-1:0]));
endmodule

bind irq_countdown_timer irq_tmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick         (tick),
   .wr_data      (wr_data),
   .start_wr     (start_wr),
   .irq_valid    (irq_valid),
   .cnt_q        (cnt_q),
   .start_q      (start_q),
   .run_q        (run_q),
   .ent_mask     (ent_mask),
   .ent_periodic (ent_periodic)
);

// File: tb/test_irq_countdown_timer.sv
`timescale 1ns/1ps
module test_irq_countdown_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic [1:0]  rd_addr = 2'd0;
   logic [31:0] rd_data;
   logic        tick = 1'b0;
   logic        irq_valid;
   logic [7:0]  irq_vector;
   logic [2:0]  irq_mode;
   logic        irq_level;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int cycles = 0;
   logic       prev_valid = 1'b0;
   logic [7:0] exp_vec = 8'd0;
   logic [2:0] exp_mode = 3'd0;
   logic       exp_lvl = 1'b0;

   always #2.5 clk = ~clk;

   irq_countdown_timer i_irq_countdown_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .tick(tick), .irq_valid(irq_valid), .irq_vector(irq_vector),
      .irq_mode(irq_mode), .irq_level(irq_level)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // Request monitor: field values (R3) and single-cycle pulses (R10)
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq_valid) begin
            pulses++;
            check("R3 vector", {24'd0, irq_vector}, {24'd0, exp_vec});
            check("R3 mode", {29'd0, irq_mode}, {29'd0, exp_mode});
            check("R3 level", {31'd0, irq_level}, {31'd0, exp_lvl});
         end
         if (prev_valid && irq_valid)
            check("R10 pulse width", 32'd2, 32'd1);
      end
      prev_valid <= irq_valid;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic drive(input logic we, input logic [1:0] a, input logic [31:0] d, input logic tk);
      wr_en = we; wr_addr = a; wr_data = d; tick = tk;
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 32'd0, 1'b1);
   endtask

   logic [31:0] v;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(2'd0, v); check("R1 entry reset", v, 32'h0001_0000);
      rd(2'd1, v); check("R1 start reset", v, 32'd0);
      rd(2'd2, v); check("R1 count reset", v, 32'd0);
      check("R1 irq idle", {31'd0, irq_valid}, 32'd0);

      // R4: reset mask suppresses the request; one-shot still stops
      pulses = 0;
      drive(1'b1, 2'd1, 32'd2, 1'b0);
      ticks(4);
      drive(1'b0, 2'd0, 32'd0, 1'b0);
      check("R4 masked after reset", pulses, 0);
      rd(2'd2, v); check("R4 masked one-shot count", v, 32'd0);

      // R9: read-back of entry and protection of the live count
      drive(1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0);
      rd(2'd0, v); check("R9 entry readback", v, 32'h0003_A7FF);
      drive(1'b1, 2'd1, 32'd9, 1'b0);
      drive(1'b1, 2'd2, 32'd77, 1'b0);
      rd(2'd2, v); check("R9 live count write ignored", v, 32'd9);

      // Sweep start value, mask and periodic bits (R3 R4 R5 R6)
      for (int n = 1; n <= 6; n++) begin
         for (int per = 0; per < 2; per++) begin
            for (int msk = 0; msk < 2; msk++) begin
               int t, gap, expp, expc, r;
               t   = 3 * n + 2;
               gap = (n == 1) ? 1 : (n % 2);
               exp_vec  = 8'((n * 37 + per * 11 + msk * 3 + 5) & 255);
               exp_mode = 3'((n + per) % 8);
               exp_lvl  = 1'((n + msk) & 1);
               drive(1'b1, 2'd0, {14'd0, 1'(per), 1'(msk), exp_lvl, 4'b0010,
                                  exp_mode, exp_vec}, 1'b0);
               drive(1'b1, 2'd1, 32'(n), 1'b0);
               pulses = 0;
               for (int k = 0; k < t; k++) begin
                  drive(1'b0, 2'd0, 32'd0, 1'b1);
                  for (int g = 0; g < gap; g++) drive(1'b0, 2'd0, 32'd0, 1'b0);
               end
               drive(1'b0, 2'd0, 32'd0, 1'b0);
               if (msk == 1)      expp = 0;
               else if (per == 1) expp = t / n;
               else               expp = 1;
               r = t % n;
               if (per == 1) expc = (r == 0) ? n : n - r;
               else          expc = 0;
               if (msk == 1) check("R4 no request when masked", pulses, expp);
               else if (per == 1) check("R5 periodic request count", pulses, expp);
               else check("R6 one-shot request count", pulses, expp);
               rd(2'd2, v);
               if (per == 1) check("R5 periodic count after ticks", v, 32'(expc));
               else check("R6 one-shot count stays zero", v, 32'(expc));
            end
         end
      end

      // R7: zero start value stops the timer
      drive(1'b1, 2'd0, 32'h0002_0000, 1'b0);   // periodic, unmasked
      drive(1'b1, 2'd1, 32'd3, 1'b0);
      ticks(1);
      drive(1'b1, 2'd1, 32'd0, 1'b0);
      pulses = 0;
      ticks(8);
      drive(1'b0, 2'd0, 32'd0, 1'b0);
      check("R7 no request after zero write", pulses, 0);
      rd(2'd2, v); check("R7 count stays zero", v, 32'd0);

      // R2 / R8: hold without tick, restart wins over tick
      exp_vec = 8'h5A; exp_mode = 3'd4; exp_lvl = 1'b1;
      drive(1'b1, 2'd0, 32'h0000_845A, 1'b0);   // one-shot, unmasked, level
      drive(1'b1, 2'd1, 32'd5, 1'b0);
      rd(2'd2, v); check("R2 load visible next cycle", v, 32'd5);
      repeat (3) drive(1'b0, 2'd0, 32'd0, 1'b0);
      rd(2'd2, v); check("R2 hold without tick", v, 32'd5);
      ticks(4);
      rd(2'd2, v); check("R2 decrement per tick", v, 32'd1);
      pulses = 0;
      drive(1'b1, 2'd1, 32'd4, 1'b1);           // write and tick at count 1
      rd(2'd2, v); check("R8 restart wins over tick", v, 32'd4);
      check("R8 no expiry on restart cycle", pulses, 0);
      ticks(3);
      drive(1'b0, 2'd0, 32'd0, 1'b0);
      check("R8 no request before new count ends", pulses, 0);
      ticks(1);
      drive(1'b0, 2'd0, 32'd0, 1'b0);
      check("R8 request after new full count", pulses, 1);
      check("R10 pulse low after one cycle", {31'd0, irq_valid}, 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule